// File: doc/BRIEF.md
# Serial DAC Command Frame Receiver

This block receives write-only command frames over a three-wire serial link (active-low select, serial clock, data) and runs them against a double-buffered pair of 10-bit code registers that feed a DAC. Each frame is 16 bits long and is sent most significant bit first. It holds a 4-bit opcode, then a 10-bit data field, then two trailing bits that must be zero. The receiver samples data on rising serial clock edges. It acts on a frame only when select returns high after exactly 16 clocks.

All three serial pins pass through two-flop synchronisers into a fast system clock. Edges are found in that domain, so the system clock must run at least four times faster than the serial clock. The block has two registers:

- A staging register, which can be written on its own.
- An output register, which drives the DAC code. It can be copied from the staging register or written together with it.

Three opcodes do not touch either register. Instead they pass a 2-bit configuration field to a separate power-mode controller, together with a one-cycle one-hot pulse that names the command. All outputs are plain levels or single-cycle pulses. The DAC code is a held register with no transfer to acknowledge, so the block has no valid/ready handshake and no back-pressure.

Top module: `dacfrm_rx`

## Requirements
- R1: After reset, `dac_code_o` is 0 (zero scale), `cfg_o` is 0, `frame_err_o` is 0, `cmd_pulse_o` is 0, and the staging register holds 0.
- R2: Frame bit 15 is sent first. Bits 15..12 are the opcode, bits 11..2 are the data with data bit 9 sent first, and bits 1..0 are the trailing bits. A command's effect appears on the outputs within 4 system clocks after `csn_i` rises.
- R3: Opcode 0001 writes the data to the staging register only. `dac_code_o` does not change, and `cmd_pulse_o[0]` pulses.
- R4: Opcode 1000 copies the staging register into the output register, and `cmd_pulse_o[1]` pulses.
- R5: Opcodes 1001 and 1111 write the data into both registers, and `cmd_pulse_o[2]` pulses.
- R6: Opcodes 1100, 1101 and 1110 load `cfg_o` from data bits 9..8 and pulse `cmd_pulse_o[3]`, `[4]` and `[5]` respectively. The other data bits and both code registers are unaffected.
- R7: Opcode 0000 and the reserved opcodes (0010 through 0111, 1010, 1011) change no register and produce no pulse.
- R8: A frame whose serial clock count at the rise of `csn_i` is not exactly 16 is discarded. No register changes, no pulse occurs and no error is raised.
- R9: A 16-clock frame with non-zero trailing bits is discarded and sets `frame_err_o`. The flag stays set through later frames until `err_clr_i` is high for a cycle.
- R10: At most one bit of `cmd_pulse_o` is high at a time, and each pulse lasts exactly one system clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk_i | input | 1 | Serial clock; data sampled on its rising edge |
| sdi_i | input | 1 | Serial data, most significant bit first |
| csn_i | input | 1 | Active-low frame select; rising edge ends the frame |
| err_clr_i | input | 1 | Clears the sticky frame error flag |
| dac_code_o | output | 10 | Output (DAC) register value |
| cfg_o | output | 2 | Last configuration field from a power-mode command |
| cmd_pulse_o | output | 6 | One-hot command pulse: load, transfer, write-through, standby, wake, shutdown |
| frame_err_o | output | 1 | Sticky flag: a frame with non-zero trailing bits was seen |

## Verification
The bench sends a frame with a loaded-only opcode and then transfers it. A design that wrote through on opcode 0001 would move the output one command early, and a transfer that copied the wrong register would leave the previous code on the output. It also sends frames of 15 and 17 clocks: a receiver that acted on a count of at least 16, or that used only the last 16 bits shifted in, would update the output for the long frame. Reserved opcodes, non-zero trailing bits and the error flag's persistence across a later valid frame are all probed at the ports. The asymmetric code 0x2A5 exposes any reversal of bit order.

// File: rtl/dacfrm_pkg.sv
package dacfrm_pkg;
  localparam int OPC_W  = 4;
  localparam int SUB_W  = 2;
  localparam int CFG_W  = 2;
  localparam int KINDS  = 6;

  typedef enum int unsigned {
    K_LOAD_IN = 0,
    K_XFER    = 1,
    K_WRITE   = 2,
    K_STBY    = 3,
    K_WAKE    = 4,
    K_OFF     = 5
  } kind_e;
endpackage

// File: rtl/dacfrm_sync.sv
module dacfrm_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] st;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= {STAGES{RST_VAL}};
    end else begin
      st[0] <= d_i;
      for (int k = 1; k < STAGES; k++) st[k] <= st[k-1];
    end
  end

  assign q_o = st[STAGES-1];
endmodule

// File: rtl/dacfrm_shift.sv
module dacfrm_shift #(
  parameter int FRAME_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sclk_s,
  input  logic               sdi_s,
  input  logic               csn_s,
  output logic               strobe_o,
  output logic               len_ok_o,
  output logic [FRAME_W-1:0] word_o
);
  localparam int CNT_CAP = FRAME_W + 1;
  localparam int CNT_W   = $clog2(CNT_CAP + 1);

  logic               prev_sclk, prev_csn;
  logic               sclk_rise, cs_rise;
  logic [CNT_W-1:0]   cnt;
  logic [FRAME_W-1:0] shreg;

  assign sclk_rise = sclk_s & ~prev_sclk;
  assign cs_rise   = csn_s & ~prev_csn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_sclk <= 1'b0;
      prev_csn  <= 1'b1;
      cnt       <= '0;
      shreg     <= '0;
    end else begin
      prev_sclk <= sclk_s;
      prev_csn  <= csn_s;
      if (csn_s) begin
        cnt <= '0;
      end else if (sclk_rise) begin
        shreg <= {shreg[FRAME_W-2:0], sdi_s};
        if (cnt != CNT_W'(CNT_CAP)) cnt <= cnt + 1'b1;
      end
    end
  end

  assign strobe_o = cs_rise;
  assign len_ok_o = (cnt == CNT_W'(FRAME_W));
  assign word_o   = shreg;

  // R8
  cnt_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    csn_s |=> (cnt == '0));

  // R2
  shift_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_rise && !csn_s) |=> (shreg[0] == $past(sdi_s)));
endmodule

// File: rtl/dacfrm_exec.sv
module dacfrm_exec
  import dacfrm_pkg::*;
#(
  parameter int DATA_W  = 10,
  parameter int FRAME_W = OPC_W + DATA_W + SUB_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               strobe_i,
  input  logic               len_ok_i,
  input  logic [FRAME_W-1:0] word_i,
  input  logic               err_clr_i,
  output logic [DATA_W-1:0]  dac_code_o,
  output logic [CFG_W-1:0]   cfg_o,
  output logic [KINDS-1:0]   pulse_o,
  output logic               err_o
);
  logic [OPC_W-1:0]  opc;
  logic [DATA_W-1:0] data;
  logic [SUB_W-1:0]  sub;
  logic [KINDS-1:0]  hit;
  logic              accept, bad_sub;
  logic [DATA_W-1:0] in_q, dac_q;
  logic [CFG_W-1:0]  cfg_q;
  logic [KINDS-1:0]  pulse_q;
  logic              err_q;

  assign opc  = word_i[FRAME_W-1 -: OPC_W];
  assign data = word_i[SUB_W +: DATA_W];
  assign sub  = word_i[SUB_W-1:0];

  always_comb begin
    hit = '0;
    case (opc)
      4'b0001:          hit[K_LOAD_IN] = 1'b1;
      4'b1000:          hit[K_XFER]    = 1'b1;
      4'b1001, 4'b1111: hit[K_WRITE]   = 1'b1;
      4'b1100:          hit[K_STBY]    = 1'b1;
      4'b1101:          hit[K_WAKE]    = 1'b1;
      4'b1110:          hit[K_OFF]     = 1'b1;
      default:          hit = '0;
    endcase
  end

  assign accept  = strobe_i & len_ok_i & (sub == '0);
  assign bad_sub = strobe_i & len_ok_i & (sub != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_q    <= '0;
      dac_q   <= '0;
      cfg_q   <= '0;
      pulse_q <= '0;
      err_q   <= 1'b0;
    end else begin
      pulse_q <= accept ? hit : '0;
      if (accept && (hit[K_LOAD_IN] || hit[K_WRITE])) in_q <= data;
      if (accept && hit[K_WRITE]) dac_q <= data;
      else if (accept && hit[K_XFER]) dac_q <= in_q;
      if (accept && (hit[K_STBY] || hit[K_WAKE] || hit[K_OFF]))
        cfg_q <= data[DATA_W-1 -: CFG_W];
      if (bad_sub) err_q <= 1'b1;
      else if (err_clr_i) err_q <= 1'b0;
    end
  end

  assign dac_code_o = dac_q;
  assign cfg_o      = cfg_q;
  assign pulse_o    = pulse_q;
  assign err_o      = err_q;

  // R10
  pulse_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pulse_q));

  // R10
  pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|pulse_q) |=> (pulse_q == '0));

  // R4
  xfer_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_q[K_XFER] |-> (dac_q == $past(in_q)));

  // R3
  dac_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dac_q) |-> (pulse_q[K_XFER] || pulse_q[K_WRITE]));

  // R9
  err_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_q) |-> $past(bad_sub));
endmodule

// File: rtl/dacfrm_rx.sv
module dacfrm_rx
  import dacfrm_pkg::*;
#(
  parameter int DATA_W      = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_i,
  input  logic              sdi_i,
  input  logic              csn_i,
  input  logic              err_clr_i,
  output logic [DATA_W-1:0] dac_code_o,
  output logic [CFG_W-1:0]  cfg_o,
  output logic [KINDS-1:0]  cmd_pulse_o,
  output logic              frame_err_o
);
  localparam int FRAME_W = OPC_W + DATA_W + SUB_W;

  logic [2:0]         pins_s;
  logic               strobe, len_ok;
  logic [FRAME_W-1:0] word;

  dacfrm_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   ({csn_i, sclk_i, sdi_i}),
    .q_o   (pins_s)
  );

  dacfrm_shift #(.FRAME_W(FRAME_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .sclk_s   (pins_s[1]),
    .sdi_s    (pins_s[0]),
    .csn_s    (pins_s[2]),
    .strobe_o (strobe),
    .len_ok_o (len_ok),
    .word_o   (word)
  );

  dacfrm_exec #(.DATA_W(DATA_W), .FRAME_W(FRAME_W)) u_exec (
    .clk        (clk),
    .rst_n      (rst_n),
    .strobe_i   (strobe),
    .len_ok_i   (len_ok),
    .word_i     (word),
    .err_clr_i  (err_clr_i),
    .dac_code_o (dac_code_o),
    .cfg_o      (cfg_o),
    .pulse_o    (cmd_pulse_o),
    .err_o      (frame_err_o)
  );
endmodule

// File: tb/dacfrm_rx_bench.sv
module dacfrm_rx_bench;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst_n = 1'b0;
  logic       sclk = 1'b0, sdi = 1'b0, csn = 1'b1, err_clr = 1'b0;
  logic [9:0] dac_code;
  logic [1:0] cfg;
  logic [5:0] pulse;
  logic       ferr;

  dacfrm_rx u_dacfrm_rx (
    .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .sdi_i(sdi), .csn_i(csn),
    .err_clr_i(err_clr), .dac_code_o(dac_code), .cfg_o(cfg),
    .cmd_pulse_o(pulse), .frame_err_o(ferr)
  );

  int checks = 0, fails = 0, multi = 0;
  int pcnt[6];
  int snap[6];
  logic [5:0] prevp = '0;

  always @(negedge clk) begin
    if (rst_n) begin
      for (int k = 0; k < 6; k++) pcnt[k] += int'(pulse[k]);
      if (prevp != 0 && pulse != 0) multi++;
      if (!$onehot0(pulse)) multi++;
      prevp = pulse;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic take();
    for (int k = 0; k < 6; k++) snap[k] = pcnt[k];
  endtask

  task automatic pulses(input string req, input int which);
    for (int k = 0; k < 6; k++)
      chk(req, pcnt[k] - snap[k], (k == which) ? 1 : 0);
  endtask

  task automatic send(input logic [3:0] op, input logic [9:0] d,
                      input logic [1:0] s, input int nb, input int settle);
    logic [15:0] w;
    w = {op, d, s};
    take();
    csn = 1'b0;
    repeat (4) @(negedge clk);
    for (int i = 0; i < nb; i++) begin
      sdi = (i < 16) ? w[15-i] : 1'b0;
      repeat (4) @(negedge clk);
      sclk = 1'b1;
      repeat (4) @(negedge clk);
      sclk = 1'b0;
    end
    repeat (4) @(negedge clk);
    csn = 1'b1;
    repeat (settle) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 dac", dac_code, 0);
    chk("R1 cfg", cfg, 0);
    chk("R1 err", ferr, 0);
    chk("R1 pulse", pulse, 0);
  endtask

  task automatic t_write();
    send(4'b1001, 10'h2A5, 2'b00, 16, 4);
    chk("R2 latency/order", dac_code, 'h2A5);
    repeat (6) @(negedge clk);
    pulses("R5 pulse 1001", 2);
    send(4'b1111, 10'h3FF, 2'b00, 16, 10);
    chk("R5 1111 full scale", dac_code, 'h3FF);
    pulses("R5 pulse 1111", 2);
  endtask

  task automatic t_stage();
    send(4'b0001, 10'h155, 2'b00, 16, 10);
    chk("R3 dac held", dac_code, 'h3FF);
    pulses("R3 pulse", 0);
    send(4'b1000, 10'h000, 2'b00, 16, 10);
    chk("R4 transfer", dac_code, 'h155);
    pulses("R4 pulse", 1);
  endtask

  task automatic t_cfg();
    send(4'b1100, 10'b10_1111_1111, 2'b00, 16, 10);
    chk("R6 cfg stby", cfg, 2);
    chk("R6 dac kept", dac_code, 'h155);
    pulses("R6 pulse stby", 3);
    send(4'b1101, 10'b01_0000_0000, 2'b00, 16, 10);
    chk("R6 cfg wake", cfg, 1);
    pulses("R6 pulse wake", 4);
    send(4'b1110, 10'b11_0101_0101, 2'b00, 16, 10);
    chk("R6 cfg off", cfg, 3);
    pulses("R6 pulse off", 5);
    send(4'b1000, 10'h000, 2'b00, 16, 10);
    chk("R6 staging untouched", dac_code, 'h155);
  endtask

  task automatic t_reserved();
    logic [3:0] ops [5] = '{4'b0000, 4'b0010, 4'b0111, 4'b1010, 4'b1011};
    for (int i = 0; i < 5; i++) begin
      send(ops[i], 10'h0AA, 2'b00, 16, 10);
      chk("R7 dac", dac_code, 'h155);
      chk("R7 cfg", cfg, 3);
      pulses("R7 no pulse", -1);
    end
    send(4'b1000, 10'h000, 2'b00, 16, 10);
    chk("R7 staging untouched", dac_code, 'h155);
  endtask

  task automatic t_length();
    send(4'b1001, 10'h001, 2'b00, 15, 10);
    chk("R8 short dac", dac_code, 'h155);
    pulses("R8 short pulse", -1);
    send(4'b1001, 10'h002, 2'b00, 17, 10);
    chk("R8 long dac", dac_code, 'h155);
    chk("R8 no err", ferr, 0);
  endtask

  task automatic t_sub();
    send(4'b1001, 10'h0F0, 2'b01, 16, 10);
    chk("R9 dac", dac_code, 'h155);
    chk("R9 err set", ferr, 1);
    pulses("R9 no pulse", -1);
    send(4'b1001, 10'h0F0, 2'b00, 16, 10);
    chk("R9 err sticky", ferr, 1);
    chk("R9 valid after", dac_code, 'h0F0);
    err_clr = 1'b1;
    @(negedge clk);
    err_clr = 1'b0;
    @(negedge clk);
    chk("R9 err cleared", ferr, 0);
  endtask

  bit done = 1'b0;

  initial begin
    for (int k = 0; k < 6; k++) pcnt[k] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_write();
    t_stage();
    t_cfg();
    t_reserved();
    t_length();
    t_sub();
    chk("R10 one-hot single-cycle", multi, 0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule